// File: doc/BRIEF.md
# Multi-Channel DMA Bus Arbiter

This block decides, every clock cycle, which master owns a shared memory bus. The candidates are the CPU, one legacy DMA engine and a parameterised set of block-based DMA channels. Each block channel is loaded with a total word count, a block size given as a power of two, a post-block pause length, a start address with a stepping mode, and a fill flag. It then moves one word per owned cycle. A block that has started always runs to its end. After each block the channel rests for its pause count, and the bus goes to the lowest-numbered other eligible channel, then to the legacy engine, then to the CPU.

A global share timer can hand the bus back to the CPU at regular intervals. Once DMA masters have owned the bus for 2^N cycles, the arbiter waits for the running block to finish. It then gives the CPU 2^N consecutive cycles and restarts the count. The legacy engine moves its whole word count in one unbroken run. It is served only when no block channel is eligible.

The grant is registered and one-hot. The address and read/write strobes describe the word moved in the current cycle.

Top module: `bus_share_arbiter`

## Requirements
- R1: `grant` is one-hot in every cycle: bit 0 means CPU, bit 1 means legacy, bit 2+n means block channel n. After reset it reads CPU (value 1), and a start pulse never changes the grant in the same cycle it is sampled.
- R2: A block channel started with a nonzero word count W owns the bus for exactly W cycles in total. `ch_done[n]` is high in the cycle of its last word. A start pulse with W=0 is ignored, so the grant stays CPU.
- R3: Blocks hold 2^`blog` words and the final block may be shorter. Once a block starts, the channel owns every following cycle until the block ends. This holds even when a lower-numbered channel becomes eligible or the share timer expires.
- R4: After a non-final block with pause count g>0, the channel is not granted for at least g cycles, and with nothing else eligible it resumes exactly g cycles later. With g=0 it can own the very next cycle.
- R5: When the bus is free (the CPU owns it, or a block or a legacy run ends), the next owner is the lowest-numbered eligible block channel, else a pending legacy transfer, else the CPU.
- R6: A legacy transfer of L words owns L consecutive cycles and cannot be interrupted. It is never granted while a block channel is eligible. `leg_done` is high on its last word.
- R7: With `share_en`=1 and P=2^`share_log`: once DMA masters have owned P cycles, at the next free point the CPU owns exactly P consecutive cycles. With `share_en`=0 the CPU is never forced.
- R8: `bus_addr` is the address of the word moved in this cycle. The channel address starts at its configured base and steps by mode: 0 = +1, 1 = −1, 2 or 3 = fixed. `bus_wr` is high on every DMA word. `bus_rd` is low for a channel in fill mode and high otherwise.
- R9: A start pulse to a channel that is not idle is ignored, and the channel finishes its original word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_start | input | NCH | Per-channel start pulse |
| ch_words | input | NCH*WCNT_W | Per-channel total word count |
| ch_blog | input | NCH*BLOG_W | Per-channel log2 block size |
| ch_gap | input | NCH*GAP_W | Per-channel post-block pause cycles |
| ch_addr | input | NCH*ADDR_W | Per-channel start address |
| ch_mode | input | NCH*2 | Per-channel address step mode |
| ch_fill | input | NCH | Per-channel fill flag (no source read) |
| leg_start | input | 1 | Legacy transfer start pulse |
| leg_words | input | WCNT_W | Legacy word count |
| share_en | input | 1 | Enable CPU time sharing |
| share_log | input | LOGF_W | log2 of share period |
| grant | output | NCH+2 | One-hot bus owner |
| bus_rd | output | 1 | Source read strobe for this cycle's word |
| bus_wr | output | 1 | Write strobe for this cycle's word |
| bus_addr | output | ADDR_W | Address of this cycle's word |
| ch_done | output | NCH | Last-word flag per channel |
| leg_done | output | 1 | Last-word flag for legacy |

## Verification
Directed patterns pin down exact grant sequences in several situations. A lone channel with a short final block separates block length from total count and pause timing. Two channels with unequal pauses show that a lower channel waits for a running block, and that a zero pause lets a channel continue. A legacy run started alongside a channel, or interrupted by a channel start, shows both the priority order and that legacy runs cannot be broken. Share-timer cases with blocks shorter and longer than the period show the exact CPU window and the wait for the block to end. Seeded random rounds then load all channels and the legacy engine together with random block sizes, pauses and share settings, and check every run length, every pause and every total against values the bench tracks itself.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SUSP, ST_RUN} chan_st_e;
   localparam int OWN_CPU = 0;
   localparam int OWN_LEG = 1;
   localparam int OWN_CH0 = 2;
   localparam logic [1:0] MODE_INC = 2'd0;
   localparam logic [1:0] MODE_DEC = 2'd1;
endpackage

// File: rtl/bsa_channel.sv
module bsa_channel
   import bsa_pkg::*;
#(
   parameter int WCNT_W = 16,
   parameter int BLOG_W = 3,
   parameter int GAP_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WCNT_W-1:0] cfg_words,
   input  logic [BLOG_W-1:0] cfg_blog,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_fill,
   input  logic              own,
   input  logic              pick,
   output logic              rdy,
   output logic              blk_last,
   output logic              done,
   output logic [ADDR_W-1:0] addr_o,
   output logic              fill_o
);
   localparam int MAX_LOG = (1 << BLOG_W) - 1;

   initial assert (MAX_LOG < WCNT_W) else $error("block size does not fit the word counter");

   chan_st_e          st_q;
   logic [WCNT_W-1:0] left_q, bleft_q, blk_sz;
   logic [GAP_W-1:0]  gap_q, gcnt_q;
   logic [BLOG_W-1:0] blog_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        mode_q;
   logic              fill_q, last_word;

   assign blk_sz    = WCNT_W'(1) << blog_q;
   assign last_word = (left_q == WCNT_W'(1));
   assign blk_last  = own && ((bleft_q == WCNT_W'(1)) || last_word);
   assign done      = own && last_word;
   assign rdy       = (st_q == ST_WAIT) || ((st_q == ST_SUSP) && (gcnt_q == GAP_W'(1))) ||
                      (blk_last && !last_word && (gap_q == '0));
   assign addr_o    = addr_q;
   assign fill_o    = fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         left_q  <= '0;
         bleft_q <= '0;
         gap_q   <= '0;
         gcnt_q  <= '0;
         blog_q  <= '0;
         addr_q  <= '0;
         mode_q  <= '0;
         fill_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start && (cfg_words != '0)) begin
               st_q   <= ST_WAIT;
               left_q <= cfg_words;
               blog_q <= cfg_blog;
               gap_q  <= cfg_gap;
               addr_q <= cfg_addr;
               mode_q <= cfg_mode;
               fill_q <= cfg_fill;
            end
            ST_WAIT: if (pick) begin
               st_q    <= ST_RUN;
               bleft_q <= blk_sz;
            end
            ST_SUSP: begin
               if (gcnt_q == GAP_W'(1)) begin
                  st_q <= pick ? ST_RUN : ST_WAIT;
                  if (pick) bleft_q <= blk_sz;
               end
               gcnt_q <= gcnt_q - GAP_W'(1);
            end
            default: begin
               left_q  <= left_q - WCNT_W'(1);
               bleft_q <= bleft_q - WCNT_W'(1);
               if (mode_q == MODE_INC)      addr_q <= addr_q + ADDR_W'(1);
               else if (mode_q == MODE_DEC) addr_q <= addr_q - ADDR_W'(1);
               if (blk_last) begin
                  if (last_word) begin
                     st_q <= ST_IDLE;
                  end else if (gap_q == '0) begin
                     st_q <= pick ? ST_RUN : ST_WAIT;
                     if (pick) bleft_q <= blk_sz;
                  end else begin
                     st_q   <= ST_SUSP;
                     gcnt_q <= gap_q;
                  end
               end
            end
         endcase
      end
   end

   assert_run_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN) == own);
   assert_block_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
      own && !blk_last |=> own);
   assert_gap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blk_last && !done && (gap_q != '0) |=> !own);
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) && start && !own |=> left_q == $past(left_q));
endmodule

// File: rtl/bsa_legacy.sv
module bsa_legacy #(
   parameter int WCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WCNT_W-1:0] cfg_words,
   input  logic              own,
   input  logic              pick,
   output logic              rdy,
   output logic              last
);
   logic              pend_q;
   logic [WCNT_W-1:0] left_q;

   assign rdy  = pend_q;
   assign last = own && (left_q == WCNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         left_q <= '0;
      end else if (own) begin
         left_q <= left_q - WCNT_W'(1);
      end else if (pend_q) begin
         if (pick) pend_q <= 1'b0;
      end else if (start && (cfg_words != '0)) begin
         pend_q <= 1'b1;
         left_q <= cfg_words;
      end
   end

   assert_leg_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
      own && !last |=> own);
   assert_leg_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !own);
endmodule

// File: rtl/bsa_share_timer.sv
module bsa_share_timer #(
   parameter int LOGF_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [LOGF_W-1:0] log_sel,
   input  logic              dma_own,
   input  logic              free,
   output logic              force_cpu,
   output logic              cpu_win
);
   localparam int TW = (1 << LOGF_W) + 1;

   initial assert (LOGF_W >= 1 && LOGF_W <= 5) else $error("share field width out of range");

   logic [TW-1:0] period, tcnt_q, tnx;
   logic          cpu_q, expire, win_end;

   assign period    = TW'(1) << log_sel;
   assign tnx       = tcnt_q + TW'(dma_own);
   assign expire    = (tnx >= period);
   assign win_end   = (tcnt_q >= period - TW'(1));
   assign force_cpu = en && (cpu_q ? !win_end : (free && expire));
   assign cpu_win   = cpu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_q  <= 1'b0;
         tcnt_q <= '0;
      end else if (!en) begin
         cpu_q  <= 1'b0;
         tcnt_q <= '0;
      end else if (cpu_q) begin
         if (win_end) begin
            cpu_q  <= 1'b0;
            tcnt_q <= '0;
         end else begin
            tcnt_q <= tcnt_q + TW'(1);
         end
      end else if (free && expire) begin
         cpu_q  <= 1'b1;
         tcnt_q <= '0;
      end else begin
         tcnt_q <= expire ? period : tnx;
      end
   end

   assert_window_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_q) |-> tcnt_q == '0);
   assert_no_force_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !cpu_q);
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
   import bsa_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int WCNT_W = 16,
   parameter int BLOG_W = 3,
   parameter int GAP_W  = 8,
   parameter int ADDR_W = 16,
   parameter int LOGF_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          ch_start,
   input  logic [NCH*WCNT_W-1:0]   ch_words,
   input  logic [NCH*BLOG_W-1:0]   ch_blog,
   input  logic [NCH*GAP_W-1:0]    ch_gap,
   input  logic [NCH*ADDR_W-1:0]   ch_addr,
   input  logic [NCH*2-1:0]        ch_mode,
   input  logic [NCH-1:0]          ch_fill,
   input  logic                    leg_start,
   input  logic [WCNT_W-1:0]       leg_words,
   input  logic                    share_en,
   input  logic [LOGF_W-1:0]       share_log,
   output logic [NCH+1:0]          grant,
   output logic                    bus_rd,
   output logic                    bus_wr,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [NCH-1:0]          ch_done,
   output logic                    leg_done
);
   localparam int NG = NCH + 2;

   initial assert (NCH >= 1 && NCH <= 16) else $error("channel count out of range");

   logic [NG-1:0]     grant_q, grant_d;
   logic [NCH-1:0]    c_rdy, c_blast, c_done, c_fill;
   logic [ADDR_W-1:0] c_addr [NCH];
   logic              l_rdy, l_last, force_cpu, cpu_win, free;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      bsa_channel #(.WCNT_W(WCNT_W), .BLOG_W(BLOG_W), .GAP_W(GAP_W), .ADDR_W(ADDR_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (ch_start[n]),
         .cfg_words(ch_words[n*WCNT_W +: WCNT_W]),
         .cfg_blog (ch_blog[n*BLOG_W +: BLOG_W]),
         .cfg_gap  (ch_gap[n*GAP_W +: GAP_W]),
         .cfg_addr (ch_addr[n*ADDR_W +: ADDR_W]),
         .cfg_mode (ch_mode[n*2 +: 2]),
         .cfg_fill (ch_fill[n]),
         .own      (grant_q[OWN_CH0+n]),
         .pick     (grant_d[OWN_CH0+n]),
         .rdy      (c_rdy[n]),
         .blk_last (c_blast[n]),
         .done     (c_done[n]),
         .addr_o   (c_addr[n]),
         .fill_o   (c_fill[n])
      );
   end

   bsa_legacy #(.WCNT_W(WCNT_W)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (leg_start),
      .cfg_words(leg_words),
      .own      (grant_q[OWN_LEG]),
      .pick     (grant_d[OWN_LEG]),
      .rdy      (l_rdy),
      .last     (l_last)
   );

   bsa_share_timer #(.LOGF_W(LOGF_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (share_en),
      .log_sel  (share_log),
      .dma_own  (!grant_q[OWN_CPU]),
      .free     (free),
      .force_cpu(force_cpu),
      .cpu_win  (cpu_win)
   );

   assign free = grant_q[OWN_CPU] | (|c_blast) | l_last;

   always_comb begin
      int sel;
      sel     = 0;
      grant_d = grant_q;
      if (free) begin
         grant_d = '0;
         for (int n = NCH - 1; n >= 0; n--) if (c_rdy[n]) sel = n;
         if (force_cpu)    grant_d[OWN_CPU]     = 1'b1;
         else if (|c_rdy)  grant_d[OWN_CH0+sel] = 1'b1;
         else if (l_rdy)   grant_d[OWN_LEG]     = 1'b1;
         else              grant_d[OWN_CPU]     = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_q <= NG'(1);
      else        grant_q <= grant_d;
   end

   always_comb begin
      bus_addr = '0;
      for (int n = 0; n < NCH; n++) if (grant_q[OWN_CH0+n]) bus_addr = bus_addr | c_addr[n];
   end

   assign grant    = grant_q;
   assign bus_wr   = !grant_q[OWN_CPU];
   assign bus_rd   = grant_q[OWN_LEG] | (|(grant_q[NG-1:OWN_CH0] & ~c_fill));
   assign ch_done  = c_done;
   assign leg_done = l_last;

   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_q) == 1);
   assert_cpu_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_win |-> grant_q[OWN_CPU]);
   assert_new_before_legacy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      free && !force_cpu && (|c_rdy) |=> !grant_q[OWN_LEG]);
   assert_done_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({c_done, l_last}));
endmodule

// File: tb/bus_share_arbiter_bench.sv
module bus_share_arbiter_bench;
   localparam int NCH = 4, WW = 16, BW = 3, GW = 8, AW = 16, LW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NCH-1:0]    ch_start = '0, ch_fill = '0;
   logic [NCH*WW-1:0] ch_words = '0;
   logic [NCH*BW-1:0] ch_blog = '0;
   logic [NCH*GW-1:0] ch_gap = '0;
   logic [NCH*AW-1:0] ch_addr = '0;
   logic [NCH*2-1:0]  ch_mode = '0;
   logic              leg_start = 1'b0, share_en = 1'b0;
   logic [WW-1:0]     leg_words = '0;
   logic [LW-1:0]     share_log = '0;
   logic [NCH+1:0]    grant;
   logic              bus_rd, bus_wr, leg_done;
   logic [AW-1:0]     bus_addr;
   logic [NCH-1:0]    ch_done;

   int total = 0, bad = 0, cyc = 0;

   always #4 clk = ~clk;

   bus_share_arbiter #(.NCH(NCH), .WCNT_W(WW), .BLOG_W(BW), .GAP_W(GW), .ADDR_W(AW), .LOGF_W(LW)) u_bus_share_arbiter (
      .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .ch_words(ch_words), .ch_blog(ch_blog),
      .ch_gap(ch_gap), .ch_addr(ch_addr), .ch_mode(ch_mode), .ch_fill(ch_fill),
      .leg_start(leg_start), .leg_words(leg_words), .share_en(share_en), .share_log(share_log),
      .grant(grant), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .ch_done(ch_done), .leg_done(leg_done));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog: run hung act=%0d exp<=150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk_run(int b, int n, string tag);
      for (int i = 0; i < n; i++) begin
         tick();
         chk(grant == (NCH+2)'(1 << b), tag, int'(grant), 1 << b);
      end
   endtask

   task automatic chk_words(int b, int n, int base, int step, bit rd, string tag);
      for (int i = 0; i < n; i++) begin
         tick();
         chk(grant == (NCH+2)'(1 << b), {tag, " grant"}, int'(grant), 1 << b);
         chk(bus_addr == AW'(base + i * step), "R8 address", int'(bus_addr), (base + i * step) & 16'hffff);
         chk(bus_rd == rd && bus_wr, "R8 strobes", {bus_rd, bus_wr}, {rd, 1'b1});
      end
   endtask

   task automatic set_ch(int n, int words, int blog, int gap, int addr, int mode, bit fill);
      ch_words[n*WW +: WW] = WW'(words);
      ch_blog[n*BW +: BW]  = BW'(blog);
      ch_gap[n*GW +: GW]   = GW'(gap);
      ch_addr[n*AW +: AW]  = AW'(addr);
      ch_mode[n*2 +: 2]    = 2'(mode);
      ch_fill[n]           = fill;
   endtask

   task automatic go(logic [NCH-1:0] mask, bit leg);
      ch_start = mask; leg_start = leg;
      tick();
      ch_start = '0; leg_start = 1'b0;
      chk(grant == 1, "R1 no grant in start cycle", int'(grant), 1);
   endtask

   // random-phase trackers
   int rem[NCH], runl[NCH], blkat[NCH], gapc[NCH], gapv[NCH], blk[NCH];
   bit started[NCH];
   int lrem, lrun, lwords;

   task automatic mon_step();
      for (int n = 0; n < NCH; n++) begin
         if (grant[2+n]) begin
            if (runl[n] == 0) begin
               if (started[n]) chk(gapc[n] >= gapv[n], "R4 pause too short", gapc[n], gapv[n]);
               started[n] = 1'b1;
               blkat[n] = (rem[n] < blk[n]) ? rem[n] : blk[n];
            end
            runl[n]++; rem[n]--;
            if (ch_done[n]) chk(rem[n] == 0, "R2 done on last word", rem[n], 0);
         end else if (runl[n] > 0) begin
            chk(runl[n] == blkat[n], "R3 block run length", runl[n], blkat[n]);
            runl[n] = 0; gapc[n] = 1;
         end else begin
            gapc[n]++;
         end
      end
      if (grant[1]) begin
         lrun++; lrem--;
      end else if (lrun > 0) begin
         chk(lrun == lwords, "R6 legacy run length", lrun, lwords);
         lrun = 0;
      end
   endtask

   function automatic bit all_idle();
      bit r = (lrem == 0) && (lrun == 0);
      for (int n = 0; n < NCH; n++) if (rem[n] != 0 || runl[n] != 0) r = 1'b0;
      return r;
   endfunction

   initial begin
      void'($urandom(32'd20417));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(grant == 1 && !bus_wr && ch_done == '0, "R1 reset grant CPU", int'(grant), 1);

      // single channel, short final block, pause 3
      set_ch(0, 10, 2, 3, 'h100, 0, 1'b0);
      go(4'b0001, 1'b0);
      chk_words(2, 4, 'h100, 1, 1'b1, "R3 first block");
      chk_run(0, 3, "R4 pause gives CPU");
      chk_words(2, 4, 'h104, 1, 1'b1, "R3 second block");
      chk_run(0, 3, "R4 pause gives CPU");
      chk_words(2, 2, 'h108, 1, 1'b1, "R3 short final block");
      chk(ch_done == 4'b0001, "R2 done flag", int'(ch_done), 1);
      chk_run(0, 2, "R2 no extra words");

      // two channels: lower waits for running block, zero pause continues
      set_ch(0, 8, 1, 2, 0, 0, 1'b0);
      set_ch(1, 4, 2, 0, 'h40, 0, 1'b0);
      go(4'b0011, 1'b0);
      chk_run(2, 2, "R5 lowest first");
      chk_run(3, 4, "R3 block not cut by ready lower channel");
      chk_run(2, 2, "R5 resume after pause");
      chk_run(0, 2, "R4 nothing eligible CPU");
      chk_run(2, 2, "R4 exact resume");
      chk_run(0, 2, "R4 pause");
      chk_run(2, 2, "R2 last block");
      chk_run(0, 2, "R2 finished");

      // legacy alone, channel started mid-run must wait
      leg_words = 5;
      go(4'b0000, 1'b1);
      chk_run(1, 1, "R6 legacy granted");
      set_ch(0, 2, 3, 0, 'h10, 0, 1'b0);
      ch_start = 4'b0001;
      chk_run(1, 1, "R6 legacy not broken");
      ch_start = '0;
      chk_run(1, 3, "R6 legacy not broken");
      chk(leg_done == 1'b1, "R6 legacy done flag", leg_done, 1);
      chk_words(2, 2, 'h10, 1, 1'b1, "R5 channel after legacy");
      chk_run(0, 2, "R5 idle CPU");

      // channel and legacy together: channel wins
      set_ch(0, 3, 3, 0, 0, 0, 1'b0);
      leg_words = 2;
      go(4'b0001, 1'b1);
      chk_run(2, 3, "R6 new channel before legacy");
      chk_run(1, 2, "R6 legacy afterwards");
      chk_run(0, 2, "R5 idle CPU");

      // share timer: period 4, blocks of 2
      share_en = 1'b1; share_log = 2;
      set_ch(0, 12, 1, 0, 0, 0, 1'b0);
      go(4'b0001, 1'b0);
      chk_run(2, 4, "R7 DMA until period");
      chk_run(0, 4, "R7 CPU window");
      chk_run(2, 4, "R7 DMA again");
      chk_run(0, 4, "R7 CPU window");
      chk_run(2, 4, "R7 DMA last");
      chk_run(0, 6, "R7 idle");
      // period 2, block of 4: block must finish first
      share_log = 1;
      set_ch(0, 8, 2, 0, 0, 0, 1'b0);
      go(4'b0001, 1'b0);
      chk_run(2, 4, "R3 block outlives timer");
      chk_run(0, 2, "R7 CPU window after block");
      chk_run(2, 4, "R7 DMA resumes");
      share_en = 1'b0;
      chk_run(0, 3, "R7 idle");

      // decrement + fill, fixed
      set_ch(1, 3, 2, 0, 'h20, 1, 1'b1);
      go(4'b0010, 1'b0);
      chk_words(3, 3, 'h20, -1, 1'b0, "R8 decrement fill");
      chk(ch_done == 4'b0010, "R2 done flag ch1", int'(ch_done), 2);
      set_ch(2, 2, 0, 0, 'h55, 2, 1'b0);
      go(4'b0100, 1'b0);
      chk_words(4, 2, 'h55, 0, 1'b1, "R8 fixed address");
      chk_run(0, 2, "R8 idle");

      // zero word count ignored, start while busy ignored
      set_ch(0, 0, 1, 0, 0, 0, 1'b0);
      go(4'b0001, 1'b0);
      chk_run(0, 3, "R2 zero count ignored");
      set_ch(0, 4, 3, 0, 0, 0, 1'b0);
      go(4'b0001, 1'b0);
      chk_words(2, 1, 0, 1, 1'b1, "R9 running");
      set_ch(0, 10, 3, 0, 'h700, 0, 1'b0);
      ch_start = 4'b0001;
      chk_words(2, 1, 1, 1, 1'b1, "R9 restart ignored");
      ch_start = '0;
      chk_words(2, 2, 2, 1, 1'b1, "R9 original count");
      chk_run(0, 3, "R9 no extra words");

      // seeded random rounds
      for (int r = 0; r < 40; r++) begin
         int guard;
         share_en  = 1'($urandom_range(0, 1));
         share_log = LW'($urandom_range(1, 3));
         for (int n = 0; n < NCH; n++) begin
            rem[n] = $urandom_range(1, 20);
            blk[n] = 1 << $urandom_range(0, 3);
            gapv[n] = $urandom_range(1, 5);
            runl[n] = 0; gapc[n] = 0; started[n] = 1'b0;
            set_ch(n, rem[n], $clog2(blk[n]), gapv[n], 0, 0, 1'b0);
         end
         lwords = $urandom_range(1, 6); lrem = lwords; lrun = 0;
         leg_words = WW'(lwords);
         go('1, 1'b1);
         guard = 0;
         while (!all_idle() && guard < 2000) begin
            tick();
            mon_step();
            guard++;
         end
         for (int n = 0; n < NCH; n++) chk(rem[n] == 0, "R2 random total words", rem[n], 0);
         chk(lrem == 0, "R6 random legacy total", lrem, 0);
         chk_run(0, 2, "R5 random idle CPU");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule